// File: doc/BRIEF.md
# Input Capture Transition Counter Channel

This block is one timer channel used as an input. It watches a single pin for a chosen kind of edge and, at each qualifying edge, stores the current value of one of two free-running timebases. It counts these captures and, when the count reaches a programmed target, it records the timestamp of that capture separately and sets an interrupt status bit. Depending on the sequencing mode, the channel then either stops until software re-initializes it (single shot) or clears its count and keeps going (continual).

Software sets up the channel through a small register port with a synchronous write and a combinational read. It then starts the channel with an initialize service request and gives it a nonzero priority. The pin passes through a two-flop synchronizer, so captures land a fixed number of cycles after the pin moves. The channel can also ask for the pin to be driven high or low. The timebases themselves come from outside the block.

Top module: `edge_capture_channel`

## Requirements
- R1: After reset every register reads 0, `irq_o` and `pin_drv_en_o` are 0, and the channel is not armed: pin edges are not counted until an initialize request is accepted.
- R2: The edge field is bits [4:2] of the control register (address 0). Code 000 captures no edge, 001 the rising edge, 010 the falling edge and 011 both edges. A write with bit 4 set leaves the stored edge selection unchanged, and control reads show bit 4 as 0.
- R3: The timebase field is bits [8:5] of the control register. Only bit 6 picks the source: 0 captures `tb1_i` and 1 captures `tb2_i`. A write with bit 8 set leaves the stored timebase field unchanged.
- R4: A pin change set up before a rising clock edge E0 is reflected in the count and last-capture registers after edge E2 and not before. The timebase value captured is the one present during the cycle just before E2.
- R5: The last-capture register (address 4) holds the timebase value of the most recent captured edge and changes at no other time.
- R6: Each captured edge adds one to the transition count (address 2). When the count reaches a nonzero maximum (address 1), the capture time goes into the final-capture register (address 3) and the status bit is set. A maximum of 0 never sets the status.
- R7: Sequencing is bits [1:0] of the host register (address 5), and only bit 0 matters. When bit 0 is 0 (single shot), the channel stops capturing once the maximum is reached and the count stays at the maximum until the next initialize request.
- R8: When sequencing bit 0 is 1 (continual), the count returns to 0 on the capture that reaches the maximum, capturing goes on, and the status bit is set again every maximum-count captures.
- R9: Service code 01 on `srv_code_i` with `srv_valid_i` arms the channel and clears the count. Other codes have no effect. While priority (host bits [3:2]) is 00, requests are ignored and no edge is counted.
- R10: The status bit is host bit 5. Writing 1 to it clears it, and a set in the same cycle takes precedence over the clear. `irq_o` is the status bit gated by the enable in host bit 4.
- R11: Pin-state field bits [1:0] of the control register: 01 drives the pin high and 10 drives it low, both through `pin_drv_en_o`/`pin_drv_val_o`. Codes 11 and 00 drive nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_i | input | 1 | Asynchronous channel pin |
| tb1_i | input | 16 | First timebase value |
| tb2_i | input | 16 | Second timebase value |
| srv_valid_i | input | 1 | Service request strobe |
| srv_code_i | input | 2 | Service request code |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 16 | Register write data |
| rd_addr_i | input | 3 | Register read address |
| rd_data_o | output | 16 | Register read data (combinational) |
| irq_o | output | 1 | Interrupt request |
| pin_drv_en_o | output | 1 | Pin drive enable |
| pin_drv_val_o | output | 1 | Pin drive level |

## Verification
The assertions assume that the pin stays stable for several cycles between changes, so every change passes through the synchronizer as one clean edge. They also assume that the timebases hold steady around each capture, and that software writes the host register with its own current field values. The stimulus changes the pin only just after a falling clock edge and then waits four cycles. It sets fresh timebase values before each pin change. It sweeps every edge code against both timebase sources and several maximum counts in both sequencing modes, predicting each count and timestamp arithmetically.

// File: rtl/cap_chan_pkg.sv
// Shared register addresses, field positions and codes for the
// input capture transition counter channel.
package cap_chan_pkg;

    localparam int unsigned REG_AW = 3;

    localparam logic [REG_AW-1:0] ADDR_CTRL  = 3'd0;
    localparam logic [REG_AW-1:0] ADDR_MAX   = 3'd1;
    localparam logic [REG_AW-1:0] ADDR_COUNT = 3'd2;
    localparam logic [REG_AW-1:0] ADDR_FINAL = 3'd3;
    localparam logic [REG_AW-1:0] ADDR_LAST  = 3'd4;
    localparam logic [REG_AW-1:0] ADDR_HOST  = 3'd5;

    // control register field positions
    localparam int unsigned PSC_LSB  = 0;
    localparam int unsigned PAC_LSB  = 2;
    localparam int unsigned PAC_KEEP = 4;
    localparam int unsigned TBS_LSB  = 5;
    localparam int unsigned TBS_KEEP = 8;
    localparam int unsigned TBS_SEL  = 1;   // bit within the timebase field

    // host register field positions
    localparam int unsigned HOST_SEQ_LSB  = 0;
    localparam int unsigned HOST_PRIO_LSB = 2;
    localparam int unsigned HOST_EN_BIT   = 4;
    localparam int unsigned HOST_STAT_BIT = 5;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_mode_e;

    typedef enum logic [1:0] {
        DRV_NONE0 = 2'b00,
        DRV_HIGH  = 2'b01,
        DRV_LOW   = 2'b10,
        DRV_NONE  = 2'b11
    } pin_force_e;

    localparam logic [1:0] SRV_INIT = 2'b01;

endpackage

// File: rtl/cap_chan_sync_edge.sv
// Pin synchronizer and edge qualifier.
// Passes the asynchronous pin through STAGES flops, then compares the
// synchronized level with its previous value and flags the edges that
// the selected mode accepts. Assumes pin pulses last several cycles.
module cap_chan_sync_edge
    import cap_chan_pkg::*;
#(
    parameter int unsigned STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_i,
    input  edge_mode_e mode_i,
    output logic       hit_o
);

    localparam int unsigned LAST = STAGES - 1;

    logic [STAGES-1:0] sync_q;
    logic              prev_q;
    logic              rise;
    logic              fall;

    // shift the pin through the synchronizer and keep the previous level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], pin_i};
            prev_q <= sync_q[LAST];
        end
    end

    assign rise = sync_q[LAST] & ~prev_q;
    assign fall = ~sync_q[LAST] & prev_q;

    // accept only the edges that the mode asks for
    always_comb begin
        unique case (mode_i)
            EDGE_RISE: hit_o = rise;
            EDGE_FALL: hit_o = fall;
            EDGE_BOTH: hit_o = rise | fall;
            default:   hit_o = 1'b0;
        endcase
    end

    // R2: no qualified edge is reported while edge detection is off
    a_r2_no_hit_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> (mode_i != EDGE_NONE));

endmodule

// File: rtl/cap_chan_core.sv
// Capture, counting and sequencing state of the channel.
// Holds the armed flag, the transition count, the last and final capture
// times and the interrupt status. An init request takes precedence over
// an edge in the same cycle, and a status set takes precedence over a clear.
module cap_chan_core #(
    parameter int unsigned TW = 16,
    parameter int unsigned CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hit_i,
    input  logic          run_i,
    input  logic          init_i,
    input  logic          continual_i,
    input  logic [CW-1:0] max_i,
    input  logic [TW-1:0] tb_i,
    input  logic          clr_stat_i,
    output logic [CW-1:0] count_o,
    output logic [TW-1:0] last_o,
    output logic [TW-1:0] final_o,
    output logic          status_o
);

    logic          armed_q;
    logic [CW-1:0] count_q;
    logic [TW-1:0] last_q;
    logic [TW-1:0] final_q;
    logic          status_q;
    logic [CW-1:0] count_inc;
    logic          take;
    logic          reach;

    assign count_inc = count_q + 1'b1;
    assign take      = hit_i & armed_q & run_i & ~init_i;
    assign reach     = take & (max_i != '0) & (count_inc == max_i);

    // arming and transition count sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            count_q <= '0;
        end else if (init_i) begin
            armed_q <= 1'b1;
            count_q <= '0;
        end else if (reach) begin
            armed_q <= continual_i;
            count_q <= continual_i ? '0 : count_inc;
        end else if (take) begin
            count_q <= count_inc;
        end
    end

    // timestamp of every capture and of the capture reaching the maximum
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q  <= '0;
            final_q <= '0;
        end else begin
            if (take)  last_q  <= tb_i;
            if (reach) final_q <= tb_i;
        end
    end

    // interrupt status: set on reaching the maximum, cleared by software
    always_ff @(posedge clk) begin
        if (!rst_n)          status_q <= 1'b0;
        else if (reach)      status_q <= 1'b1;
        else if (clr_stat_i) status_q <= 1'b0;
    end

    assign count_o  = count_q;
    assign last_o   = last_q;
    assign final_o  = final_q;
    assign status_o = status_q;

    // R6: the count only steps by one or returns to zero
    a_r6_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(count_q) |-> ((count_q == $past(count_q) + 1'b1) || (count_q == '0)));

    // R5: the last capture time moves only after a qualified, armed edge
    a_r5_last_on_capture: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(last_q) |-> $past(hit_i && armed_q && run_i));

    // R6: the final capture time only moves together with a status set
    a_r6_final_with_status: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(final_q) |-> status_q);

    // R7: single shot disarms after reaching the maximum
    a_r7_single_shot_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (reach && !continual_i) |=> !armed_q);

    // R9: status never rises while the channel is disabled
    a_r9_status_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_q) |-> $past(run_i));

endmodule

// File: rtl/edge_capture_channel.sv
// Input capture transition counter channel, top level.
// Holds the control, maximum-count and host registers, selects the
// timebase, decodes service requests and the pin-force request, and
// wires the synchronizer/edge qualifier to the capture core.
// Assumes TW and CW do not exceed DW and DW is at least 9.
module edge_capture_channel
    import cap_chan_pkg::*;
#(
    parameter int unsigned TW     = 16,
    parameter int unsigned CW     = 16,
    parameter int unsigned DW     = 16,
    parameter int unsigned STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pin_i,
    input  logic [TW-1:0]     tb1_i,
    input  logic [TW-1:0]     tb2_i,
    input  logic              srv_valid_i,
    input  logic [1:0]        srv_code_i,
    input  logic              wr_en_i,
    input  logic [REG_AW-1:0] wr_addr_i,
    input  logic [DW-1:0]     wr_data_i,
    input  logic [REG_AW-1:0] rd_addr_i,
    output logic [DW-1:0]     rd_data_o,
    output logic              irq_o,
    output logic              pin_drv_en_o,
    output logic              pin_drv_val_o
);

    logic [1:0]    psc_q;
    logic [1:0]    pac_q;
    logic [3:0]    tbs_q;
    logic [CW-1:0] max_q;
    logic [1:0]    seq_q;
    logic [1:0]    prio_q;
    logic          int_en_q;

    logic          wr_ctrl;
    logic          wr_host;
    logic          run;
    logic          init_req;
    logic          clr_stat;
    logic          hit;
    logic [TW-1:0] tb_sel;
    logic [CW-1:0] count;
    logic [TW-1:0] last_time;
    logic [TW-1:0] final_time;
    logic          status;

    assign wr_ctrl  = wr_en_i & (wr_addr_i == ADDR_CTRL);
    assign wr_host  = wr_en_i & (wr_addr_i == ADDR_HOST);
    assign run      = (prio_q != 2'b00);
    assign init_req = srv_valid_i & (srv_code_i == SRV_INIT) & run;
    assign clr_stat = wr_host & wr_data_i[HOST_STAT_BIT];

    // control register with keep-unchanged codes on edge and timebase fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            psc_q <= 2'b00;
            pac_q <= 2'b00;
            tbs_q <= 4'b0000;
        end else if (wr_ctrl) begin
            psc_q <= wr_data_i[PSC_LSB +: 2];
            if (!wr_data_i[PAC_KEEP]) pac_q <= wr_data_i[PAC_LSB +: 2];
            if (!wr_data_i[TBS_KEEP]) tbs_q <= wr_data_i[TBS_LSB +: 4];
        end
    end

    // maximum-count register
    always_ff @(posedge clk) begin
        if (!rst_n)                                max_q <= '0;
        else if (wr_en_i && wr_addr_i == ADDR_MAX) max_q <= wr_data_i[CW-1:0];
    end

    // host register: sequencing, priority and interrupt enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q    <= 2'b00;
            prio_q   <= 2'b00;
            int_en_q <= 1'b0;
        end else if (wr_host) begin
            seq_q    <= wr_data_i[HOST_SEQ_LSB +: 2];
            prio_q   <= wr_data_i[HOST_PRIO_LSB +: 2];
            int_en_q <= wr_data_i[HOST_EN_BIT];
        end
    end

    // pick the timebase that the capture latches
    assign tb_sel = tbs_q[TBS_SEL] ? tb2_i : tb1_i;

    cap_chan_sync_edge #(
        .STAGES (STAGES)
    ) u_sync_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (pin_i),
        .mode_i (edge_mode_e'(pac_q)),
        .hit_o  (hit)
    );

    cap_chan_core #(
        .TW (TW),
        .CW (CW)
    ) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .hit_i       (hit),
        .run_i       (run),
        .init_i      (init_req),
        .continual_i (seq_q[0]),
        .max_i       (max_q),
        .tb_i        (tb_sel),
        .clr_stat_i  (clr_stat),
        .count_o     (count),
        .last_o      (last_time),
        .final_o     (final_time),
        .status_o    (status)
    );

    // register read multiplexer
    always_comb begin
        rd_data_o = '0;
        unique case (rd_addr_i)
            ADDR_CTRL: begin
                rd_data_o[PSC_LSB +: 2] = psc_q;
                rd_data_o[PAC_LSB +: 2] = pac_q;
                rd_data_o[TBS_LSB +: 4] = tbs_q;
            end
            ADDR_MAX:   rd_data_o[CW-1:0] = max_q;
            ADDR_COUNT: rd_data_o[CW-1:0] = count;
            ADDR_FINAL: rd_data_o[TW-1:0] = final_time;
            ADDR_LAST:  rd_data_o[TW-1:0] = last_time;
            ADDR_HOST: begin
                rd_data_o[HOST_SEQ_LSB +: 2]  = seq_q;
                rd_data_o[HOST_PRIO_LSB +: 2] = prio_q;
                rd_data_o[HOST_EN_BIT]        = int_en_q;
                rd_data_o[HOST_STAT_BIT]      = status;
            end
            default: rd_data_o = '0;
        endcase
    end

    // interrupt output and pin-force request
    assign irq_o = status & int_en_q;

    always_comb begin
        unique case (pin_force_e'(psc_q))
            DRV_HIGH: begin pin_drv_en_o = 1'b1; pin_drv_val_o = 1'b1; end
            DRV_LOW:  begin pin_drv_en_o = 1'b1; pin_drv_val_o = 1'b0; end
            default:  begin pin_drv_en_o = 1'b0; pin_drv_val_o = 1'b0; end
        endcase
    end

    // R9: nothing is counted or cleared while priority is disabled
    a_r9_idle_holds_count: assert property (@(posedge clk) disable iff (!rst_n)
        (prio_q == 2'b00) |=> $stable(count));

    // R10: an interrupt is never raised without a pending status
    a_r10_irq_has_status: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (status && int_en_q));

endmodule

// File: tb/edge_capture_channel_bench.sv
`timescale 1ns/1ps
module edge_capture_channel_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pin_i = 1'b0;
    logic [15:0] tb1_i = 16'h0;
    logic [15:0] tb2_i = 16'h0;
    logic        srv_valid_i = 1'b0;
    logic [1:0]  srv_code_i = 2'b00;
    logic        wr_en_i = 1'b0;
    logic [2:0]  wr_addr_i = 3'd0;
    logic [15:0] wr_data_i = 16'h0;
    logic [2:0]  rd_addr_i = 3'd0;
    logic [15:0] rd_data_o;
    logic        irq_o;
    logic        pin_drv_en_o;
    logic        pin_drv_val_o;

    int n_checks = 0;
    int n_fail   = 0;
    int kidx     = 0;
    bit done     = 0;

    always #2 clk = ~clk;

    edge_capture_channel u_edge_capture_channel (
        .clk           (clk),
        .rst_n         (rst_n),
        .pin_i         (pin_i),
        .tb1_i         (tb1_i),
        .tb2_i         (tb2_i),
        .srv_valid_i   (srv_valid_i),
        .srv_code_i    (srv_code_i),
        .wr_en_i       (wr_en_i),
        .wr_addr_i     (wr_addr_i),
        .wr_data_i     (wr_data_i),
        .rd_addr_i     (rd_addr_i),
        .rd_data_o     (rd_data_o),
        .irq_o         (irq_o),
        .pin_drv_en_o  (pin_drv_en_o),
        .pin_drv_val_o (pin_drv_val_o)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // every task starts just after a falling edge and returns on one
    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic srv(input logic [1:0] code);
        srv_valid_i = 1'b1; srv_code_i = code;
        @(negedge clk);
        srv_valid_i = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] v);
        rd_addr_i = a;
        #1;
        v = rd_data_o;
        @(negedge clk);
    endtask

    task automatic fresh_tb();
        kidx++;
        tb1_i = 16'h1000 + 16'(kidx * 7);
        tb2_i = 16'hC000 - 16'(kidx * 5);
    endtask

    task automatic pin_set(input logic v);
        pin_i = v;
        repeat (4) @(negedge clk);
    endtask

    function automatic logic [15:0] ctrl(input int tbs, input int pac, input int psc);
        return 16'((tbs << 5) | (pac << 2) | psc);
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [15:0] v;
        logic [15:0] exp_last;
        logic [15:0] exp_final;
        int exp_cnt;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset values
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), v);
            chk("R1 reset register", v, 16'h0);
        end
        chk("R1 reset irq", {15'b0, irq_o}, 16'h0);
        chk("R1 reset drive", {15'b0, pin_drv_en_o}, 16'h0);

        // R1: not armed before init, edges are not counted
        wr(3'd5, 16'h0014);
        wr(3'd0, ctrl(0, 1, 3));
        fresh_tb(); pin_set(1'b1);
        fresh_tb(); pin_set(1'b0);
        rd(3'd2, v); chk("R1 unarmed count", v, 16'h0);
        rd(3'd4, v); chk("R1 unarmed last", v, 16'h0);

        // R2/R3/R5/R6: sweep edge codes against both timebases, max 0
        wr(3'd1, 16'h0);
        exp_last = 16'h0;
        for (int pac = 0; pac < 4; pac++) begin
            for (int sel = 0; sel < 2; sel++) begin
                wr(3'd0, ctrl(sel * 2, pac, 3));
                srv(2'b01);
                exp_cnt = 0;
                for (int e = 0; e < 4; e++) begin
                    logic lvl;
                    bit q;
                    lvl = (e % 2 == 0);
                    fresh_tb();
                    pin_set(lvl);
                    q = (pac == 3) || (pac == 1 && lvl) || (pac == 2 && !lvl);
                    if (q) begin
                        exp_cnt++;
                        exp_last = (sel == 1) ? tb2_i : tb1_i;
                    end
                    rd(3'd2, v); chk("R2 edge count", v, 16'(exp_cnt));
                    rd(3'd4, v); chk("R3 R5 last capture", v, exp_last);
                end
                rd(3'd5, v); chk("R6 max zero no status", v & 16'h0020, 16'h0);
            end
        end

        // R2/R3: keep-unchanged codes
        wr(3'd0, ctrl(0, 1, 3));
        wr(3'd0, ctrl(4'b1010, 3'b111, 3));
        rd(3'd0, v); chk("R2 R3 keep readback", v, ctrl(0, 1, 3));
        srv(2'b01);
        fresh_tb(); pin_set(1'b1);
        rd(3'd2, v); chk("R2 kept rising", v, 16'h1);
        rd(3'd4, v); chk("R3 kept timebase", v, tb1_i);
        fresh_tb(); pin_set(1'b0);
        rd(3'd2, v); chk("R2 kept rising ignores fall", v, 16'h1);

        // R4: capture latency through the synchronizer
        fresh_tb();
        pin_i = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rd(3'd2, v); chk("R4 not before third edge", v, 16'h1);
        rd(3'd2, v); chk("R4 after third edge", v, 16'h2);
        rd(3'd4, v); chk("R4 captured time", v, tb1_i);
        pin_set(1'b0);

        // R9: priority 00 ignores edges and requests; codes other than 01 ignored
        wr(3'd5, 16'h0010);
        fresh_tb(); pin_set(1'b1);
        fresh_tb(); pin_set(1'b0);
        rd(3'd2, v); chk("R9 disabled no count", v, 16'h2);
        srv(2'b01);
        rd(3'd2, v); chk("R9 disabled init ignored", v, 16'h2);
        wr(3'd5, 16'h0014);
        srv(2'b10);
        srv(2'b11);
        rd(3'd2, v); chk("R9 other codes ignored", v, 16'h2);
        srv(2'b01);
        rd(3'd2, v); chk("R9 init clears count", v, 16'h0);

        // R6/R7: single shot for several maximum counts
        for (int m = 1; m <= 4; m++) begin
            bit armed;
            bit stat;
            wr(3'd1, 16'(m));
            wr(3'd5, 16'h0034);
            srv(2'b01);
            armed = 1; stat = 0; exp_cnt = 0;
            for (int p = 0; p < 6; p++) begin
                fresh_tb();
                pin_set(1'b1);
                if (armed) begin
                    exp_cnt++;
                    exp_last = tb1_i;
                    if (exp_cnt == m) begin
                        exp_final = tb1_i; stat = 1; armed = 0;
                    end
                end
                pin_set(1'b0);
            end
            rd(3'd2, v); chk("R7 single shot count holds", v, 16'(exp_cnt));
            rd(3'd4, v); chk("R7 no capture after stop", v, exp_last);
            rd(3'd3, v); chk("R6 final capture", v, exp_final);
            rd(3'd5, v); chk("R6 status set", v & 16'h0020, 16'(stat) << 5);
            chk("R10 irq enabled", {15'b0, irq_o}, 16'h1);
            wr(3'd5, 16'h0034);
            rd(3'd5, v); chk("R10 W1C clears status", v & 16'h0020, 16'h0);
            chk("R10 irq cleared", {15'b0, irq_o}, 16'h0);
        end

        // R8: continual, maximum 3
        wr(3'd1, 16'h3);
        wr(3'd5, 16'h0035);
        srv(2'b01);
        exp_cnt = 0;
        for (int p = 1; p <= 7; p++) begin
            fresh_tb();
            pin_set(1'b1);
            exp_cnt = (exp_cnt + 1) % 3;
            if (p % 3 == 0) exp_final = tb1_i;
            rd(3'd2, v); chk("R8 continual count", v, 16'(exp_cnt));
            if (p % 3 == 0) begin
                rd(3'd5, v); chk("R8 status each period", v & 16'h0020, 16'h0020);
                rd(3'd3, v); chk("R8 final updated", v, exp_final);
                if (p == 3) wr(3'd5, 16'h0035);
            end else if (p == 4 || p == 5) begin
                rd(3'd5, v); chk("R8 status between periods", v & 16'h0020, 16'h0);
            end
            pin_set(1'b0);
        end

        // R10: enable gates irq while status is pending
        wr(3'd5, 16'h0005);
        rd(3'd5, v); chk("R10 status pending", v & 16'h0020, 16'h0020);
        chk("R10 irq masked", {15'b0, irq_o}, 16'h0);
        wr(3'd5, 16'h0015);
        chk("R10 irq unmasked", {15'b0, irq_o}, 16'h1);

        // R11: pin-state codes
        for (int c = 0; c < 4; c++) begin
            wr(3'd0, ctrl(0, 1, c));
            chk("R11 drive enable", {15'b0, pin_drv_en_o}, (c == 1 || c == 2) ? 16'h1 : 16'h0);
            chk("R11 drive level", {15'b0, pin_drv_val_o}, (c == 1) ? 16'h1 : 16'h0);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule